// File: doc/BRIEF.md
# Local Interval Tick Timer

A per-core countdown timer built from two cascaded stages. A prescaler divides the input clock into ticks. An interval counter counts those ticks down and sets a sticky interrupt status bit when it runs out. In one-shot mode the interval counter then rests at zero until software restarts it. In interval mode it reloads from its buffer and keeps raising events every period, with no software action needed.

Software reaches the block through a simple register port. Writes are accepted in one cycle and reads are combinational. Writes to the prescale buffer, the interval buffer and the control register do not act at once. Each one lands a fixed number of cycles later, and in the cycle it lands a sticky write-status bit confirms it. Software polls that bit and clears it by writing 1. A new interval count is only taken when the write also carries an update flag. The interrupt output is a level that stays high until the status bit is cleared.

Top module: `local_tick_timer`

## Requirements
- R1: After reset every register reads zero (prescale 0x00, interval buffer 0x08, current count 0x0C, control 0x20, status 0x30, enable 0x34, write status 0x40) and `irq` is low.
- R2: A write to 0x00, 0x08 or 0x20 takes effect exactly WR_DELAY cycles after the cycle it is accepted. In that same cycle the matching write-status bit at 0x40 sets: bit 0 for 0x00, bit 1 for 0x08, bit 3 for 0x20. Until then, reads return the old value.
- R3: Write-status bits are sticky. Writing 1 to a bit of 0x40 clears that bit, and writing 0 leaves it unchanged.
- R4: With control bit 0 set, the prescaler issues one tick every P+1 cycles, where P is bits [PRE_W-1:0] of 0x00.
- R5: A write to 0x08 loads bits [COUNT_W-1:0] into both the interval buffer and the current count only when bit 31 of the written word is 1. Without that flag, neither the buffer nor the count changes.
- R6: One-shot mode (control bits 0 and 1 set, bit 2 clear): status bit 0 at 0x30 sets N*(P+1) cycles after the control write lands. The current count then holds at 0, and no further event follows.
- R7: Interval mode (control bit 2 set): on each expiry the count reloads from the buffer and status sets again, every N*(P+1) cycles, without stopping.
- R8: Status bit 0 at 0x30 stays set until 1 is written to bit 0 of 0x30.
- R9: `irq` equals status bit 0 AND bit 0 of the enable register at 0x34, and it stays high until the status is cleared.
- R10: Clearing the start bits in control freezes the current count, and no further status is raised.
- R11: A control write that lands with bit 1 going from 0 to 1 reloads the current count from the interval buffer. A write that lands with bit 0 going from 0 to 1 restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: WR_DELAY of 3, an 8-bit prescaler and a 31-bit interval count. With these values the write-landing cycle can be told apart from the cycle after acceptance. Prescale values from 0 to 4 with counts from 2 to 16 keep each period short, so several periods of interval mode and exact one-shot timing fit in a short run. The narrow prescaler still exercises its full reload path, including the divide-by-one case where a tick comes every cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_PRESCALE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_COUNT_BUF = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_COUNT_NOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_CONTROL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_INT_STAT  = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_INT_EN    = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_WR_STAT   = 8'h40;

  localparam int CTL_RUN     = 0;
  localparam int CTL_INT_RUN = 1;
  localparam int CTL_AUTO    = 2;
  localparam int WS_PRE      = 0;
  localparam int WS_CNT      = 1;
  localparam int WS_CTL      = 3;
  localparam int UPDATE_BIT  = 31;

  typedef enum logic [1:0] {
    TGT_NONE, TGT_PRESCALE, TGT_COUNT, TGT_CONTROL
  } wrTarget_e;

  typedef struct packed {
    logic restartPre;
    logic restartInt;
    logic loadCount;
  } dpStrobe_t;
endpackage

// File: rtl/tick_timer_dp.sv
module tick_timer_dp
  import tick_timer_pkg::*;
#(
  parameter int PRE_W   = 8,
  parameter int COUNT_W = 31
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          st,
  input  logic [COUNT_W-1:0] newCount,
  input  logic [COUNT_W-1:0] countBuf,
  input  logic [PRE_W-1:0]   preBuf,
  input  logic               timerRun,
  input  logic               intRun,
  input  logic               autoReload,
  output logic               expire,
  output logic [COUNT_W-1:0] curCount
);
  localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

  logic [PRE_W-1:0]   preCnt;
  logic [COUNT_W-1:0] intCnt;
  logic               tick;

  assign tick   = timerRun && !st.restartPre && (preCnt == '0);
  assign expire = tick && intRun && !st.restartInt && !st.loadCount &&
                  (intCnt == CNT_ONE);
  assign curCount = intCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (st.restartPre) begin
      preCnt <= preBuf;
    end else if (timerRun) begin
      preCnt <= (preCnt == '0) ? preBuf : preCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCnt <= '0;
    end else if (st.loadCount) begin
      intCnt <= newCount;
    end else if (st.restartInt) begin
      intCnt <= countBuf;
    end else if (tick && intRun && (intCnt != '0)) begin
      if (intCnt == CNT_ONE) intCnt <= autoReload ? countBuf : '0;
      else                   intCnt <= intCnt - 1'b1;
    end
  end

  AST_TICK_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> preCnt == $past(preBuf)); // R4
  AST_ONESHOT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    expire && !autoReload |=> intCnt == '0); // R6
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    expire && autoReload |=> intCnt == $past(countBuf)); // R7
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    !timerRun && !st.restartInt && !st.loadCount |=> $stable(intCnt)); // R10
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int COUNT_W  = 31,
  parameter int WR_DELAY = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic               expire,
  input  logic [COUNT_W-1:0] curCount,
  output dpStrobe_t          st,
  output logic [COUNT_W-1:0] newCount,
  output logic [COUNT_W-1:0] countBuf,
  output logic [PRE_W-1:0]   preBuf,
  output logic               timerRun,
  output logic               intRun,
  output logic               autoReload,
  output logic               irq
);
  localparam int LAST = WR_DELAY - 1;

  wrTarget_e          inTgt;
  logic               stgValid [WR_DELAY];
  wrTarget_e          stgTgt   [WR_DELAY];
  logic [DATA_W-1:0]  stgData  [WR_DELAY];
  logic               applyValid;
  wrTarget_e          applyTgt;
  logic [DATA_W-1:0]  applyData;
  logic [2:0]         ctrlReg;
  logic               intStat;
  logic               intEn;
  logic [3:0]         wrStat;
  logic               statClear;
  logic               wsWrite;

  always_comb begin
    inTgt = TGT_NONE;
    if (wrEn) begin
      case (wrAddr)
        OFF_PRESCALE:  inTgt = TGT_PRESCALE;
        OFF_COUNT_BUF: inTgt = TGT_COUNT;
        OFF_CONTROL:   inTgt = TGT_CONTROL;
        default:       inTgt = TGT_NONE;
      endcase
    end
  end

  for (genvar k = 0; k < WR_DELAY; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stgValid[k] <= 1'b0;
          stgTgt[k]   <= TGT_NONE;
          stgData[k]  <= '0;
        end else begin
          stgValid[k] <= (inTgt != TGT_NONE);
          stgTgt[k]   <= inTgt;
          stgData[k]  <= wrData;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          stgValid[k] <= 1'b0;
          stgTgt[k]   <= TGT_NONE;
          stgData[k]  <= '0;
        end else begin
          stgValid[k] <= stgValid[k-1];
          stgTgt[k]   <= stgTgt[k-1];
          stgData[k]  <= stgData[k-1];
        end
      end
    end
  end

  assign applyValid = stgValid[LAST];
  assign applyTgt   = stgTgt[LAST];
  assign applyData  = stgData[LAST];

  assign st.loadCount  = applyValid && (applyTgt == TGT_COUNT) && applyData[UPDATE_BIT];
  assign st.restartPre = applyValid && (applyTgt == TGT_CONTROL) &&
                         applyData[CTL_RUN] && !ctrlReg[CTL_RUN];
  assign st.restartInt = applyValid && (applyTgt == TGT_CONTROL) &&
                         applyData[CTL_INT_RUN] && !ctrlReg[CTL_INT_RUN];
  assign newCount   = applyData[COUNT_W-1:0];
  assign timerRun   = ctrlReg[CTL_RUN];
  assign intRun     = ctrlReg[CTL_INT_RUN];
  assign autoReload = ctrlReg[CTL_AUTO];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preBuf   <= '0;
      countBuf <= '0;
      ctrlReg  <= '0;
    end else if (applyValid) begin
      case (applyTgt)
        TGT_PRESCALE: preBuf  <= applyData[PRE_W-1:0];
        TGT_COUNT:    if (applyData[UPDATE_BIT]) countBuf <= applyData[COUNT_W-1:0];
        TGT_CONTROL:  ctrlReg <= applyData[2:0];
        default:      ;
      endcase
    end
  end

  assign wsWrite   = wrEn && (wrAddr == OFF_WR_STAT);
  assign statClear = wrEn && (wrAddr == OFF_INT_STAT) && wrData[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStat <= '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (wsWrite && wrData[b]) wrStat[b] <= 1'b0;
      end
      if (applyValid) begin
        case (applyTgt)
          TGT_PRESCALE: wrStat[WS_PRE] <= 1'b1;
          TGT_COUNT:    wrStat[WS_CNT] <= 1'b1;
          TGT_CONTROL:  wrStat[WS_CTL] <= 1'b1;
          default:      ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intStat <= 1'b0;
      intEn   <= 1'b0;
    end else begin
      if (expire)         intStat <= 1'b1;
      else if (statClear) intStat <= 1'b0;
      if (wrEn && (wrAddr == OFF_INT_EN)) intEn <= wrData[0];
    end
  end

  assign irq = intStat && intEn;

  always_comb begin
    case (rdAddr)
      OFF_PRESCALE:  rdData = DATA_W'(preBuf);
      OFF_COUNT_BUF: rdData = DATA_W'(countBuf);
      OFF_COUNT_NOW: rdData = DATA_W'(curCount);
      OFF_CONTROL:   rdData = DATA_W'(ctrlReg);
      OFF_INT_STAT:  rdData = DATA_W'(intStat);
      OFF_INT_EN:    rdData = DATA_W'(intEn);
      OFF_WR_STAT:   rdData = {{(DATA_W-4){1'b0}}, wrStat[WS_CTL], 1'b0,
                               wrStat[WS_CNT], wrStat[WS_PRE]};
      default:       rdData = '0;
    endcase
  end

  AST_CTL_CONFIRM: assert property (@(posedge clk) disable iff (!rstN)
    applyValid && applyTgt == TGT_CONTROL |=> wrStat[WS_CTL]); // R2
  AST_WS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    wrStat[WS_PRE] && !(wsWrite && wrData[WS_PRE]) |=> wrStat[WS_PRE]); // R3
  AST_NOFLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    applyValid && applyTgt == TGT_COUNT && !applyData[UPDATE_BIT] |=> $stable(countBuf)); // R5
  AST_EXPIRE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> intStat); // R6
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    intStat && !statClear |=> intStat); // R8
endmodule

// File: rtl/local_tick_timer.sv
module local_tick_timer
  import tick_timer_pkg::*;
#(
  parameter int PRE_W    = 8,
  parameter int COUNT_W  = 31,
  parameter int WR_DELAY = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [7:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic [7:0]  rdAddr,
  output logic [31:0] rdData,
  output logic        irq
);
  dpStrobe_t          st;
  logic [COUNT_W-1:0] newCount;
  logic [COUNT_W-1:0] countBuf;
  logic [COUNT_W-1:0] curCount;
  logic [PRE_W-1:0]   preBuf;
  logic               timerRun;
  logic               intRun;
  logic               autoReload;
  logic               expire;

  tick_timer_ctrl #(.PRE_W(PRE_W), .COUNT_W(COUNT_W), .WR_DELAY(WR_DELAY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .expire(expire), .curCount(curCount),
    .st(st), .newCount(newCount), .countBuf(countBuf), .preBuf(preBuf),
    .timerRun(timerRun), .intRun(intRun), .autoReload(autoReload), .irq(irq)
  );

  tick_timer_dp #(.PRE_W(PRE_W), .COUNT_W(COUNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .newCount(newCount), .countBuf(countBuf),
    .preBuf(preBuf), .timerRun(timerRun), .intRun(intRun),
    .autoReload(autoReload), .expire(expire), .curCount(curCount)
  );
endmodule

// File: tb/local_tick_timer_test.sv
`timescale 1ns/1ps
module local_tick_timer_test;
  localparam int D = 3;
  localparam int NV = 6;
  localparam int VPRE  [NV] = '{0, 2, 3, 1, 4, 0};
  localparam int VCNT  [NV] = '{5, 4, 3, 7, 2, 16};
  localparam int VAUTO [NV] = '{0, 0, 1, 1, 1, 0};

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [7:0] wrAddr = 0, rdAddr = 0;
  logic [31:0] wrData = 0, rdData;
  logic irq;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  local_tick_timer uut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    rdAddr = a; #0.5; d = rdData;
  endtask

  task automatic waitApply();
    repeat (D) @(negedge clk);
  endtask

  task automatic waitIrq(output int t);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    t = cyc;
  endtask

  initial begin
    logic [31:0] v, c1, c2;
    int t0, t1, t2, per;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    // R1 reset state
    foreach (VPRE[i]) ; // no-op keeps table referenced early
    regRead(8'h00, v); check("R1 prescale", v, 0);
    regRead(8'h08, v); check("R1 count buffer", v, 0);
    regRead(8'h0C, v); check("R1 current count", v, 0);
    regRead(8'h20, v); check("R1 control", v, 0);
    regRead(8'h30, v); check("R1 status", v, 0);
    regRead(8'h40, v); check("R1 write status", v, 0);
    check("R1 irq", irq, 0);

    // R2 write lands after D cycles, confirm bit with it
    regWrite(8'h00, 32'h55);
    repeat (D - 1) @(negedge clk);
    regRead(8'h00, v); check("R2 old value before landing", v, 0);
    regRead(8'h40, v); check("R2 confirm not yet set", v[0], 0);
    @(negedge clk);
    regRead(8'h00, v); check("R2 new value landed", v, 32'h55);
    regRead(8'h40, v); check("R2 prescale confirm bit0", v[0], 1);
    // R3 write-1-to-clear
    regWrite(8'h40, 32'h0);
    regRead(8'h40, v); check("R3 write 0 keeps bit", v[0], 1);
    regWrite(8'h40, 32'h1);
    regRead(8'h40, v); check("R3 write 1 clears bit", v[0], 0);

    // R5 count load needs update flag
    regWrite(8'h08, 32'h8000_0009); waitApply();
    regRead(8'h40, v); check("R2 count confirm bit1", v[1], 1);
    regWrite(8'h08, 32'h0000_0004); waitApply();
    regRead(8'h08, v); check("R5 no flag keeps buffer", v, 9);
    regRead(8'h0C, v); check("R5 no flag keeps count", v, 9);

    // table of vectors: R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      per = VCNT[i] * (VPRE[i] + 1);
      regWrite(8'h20, 0); waitApply();
      regWrite(8'h30, 1);
      regWrite(8'h40, 32'hB);
      regWrite(8'h00, VPRE[i]);
      regWrite(8'h08, 32'h8000_0000 | VCNT[i]);
      regWrite(8'h34, 1);
      waitApply();
      regWrite(8'h20, VAUTO[i] ? 7 : 3);
      regRead(8'h40, v);
      while (!v[3]) begin @(negedge clk); regRead(8'h40, v); end
      t0 = cyc;
      waitIrq(t1);
      check(VAUTO[i] ? "R7 R4 first period" : "R6 R4 one-shot period", t1 - t0, per);
      if (VAUTO[i]) begin
        regWrite(8'h30, 1);
        waitIrq(t2);
        check("R7 auto-reload period", t2 - t1, per);
        regWrite(8'h30, 1);
        waitIrq(t0);
        check("R7 third period", t0 - t2, per);
      end else begin
        regRead(8'h0C, v); check("R6 count holds zero", v, 0);
        regWrite(8'h30, 1);
        repeat (2 * per + 4) @(negedge clk);
        check("R6 no second event", irq, 0);
      end
    end

    // R11 restart reloads from buffer (last vector: one-shot, count 16)
    regWrite(8'h20, 1); waitApply();
    regWrite(8'h30, 1);
    regWrite(8'h20, 3); waitApply();
    regRead(8'h0C, v); check("R11 restart reload", v, 16);
    repeat (20) @(negedge clk);
    check("R11 restart fires again", irq, 1);

    // R9 irq gating
    regWrite(8'h34, 0);
    check("R9 disabled irq low", irq, 0);
    regRead(8'h30, v); check("R8 status still set", v, 1);
    regWrite(8'h34, 1);
    check("R9 enabled irq high", irq, 1);
    regWrite(8'h30, 1);
    check("R9 irq drops on clear", irq, 0);

    // R10 stop freezes count
    regWrite(8'h20, 0); waitApply();
    regWrite(8'h00, 0);
    regWrite(8'h08, 32'h8000_0028); waitApply();
    regWrite(8'h20, 7); repeat (D + 5) @(negedge clk);
    regWrite(8'h20, 0); waitApply();
    regWrite(8'h30, 1);
    regRead(8'h0C, c1);
    repeat (60) @(negedge clk);
    regRead(8'h0C, c2);
    check("R10 count frozen", c2, c1);
    check("R10 count moved before stop", (c1 < 40), 1);
    check("R10 no event while stopped", irq, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1-timeout actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule